// File: doc/BRIEF.md
# UART Internal Loopback and Modem-Status Mapper

This block sits between a UART's programming interface and its receive FIFO. It selects what enters the receive FIFO. In normal operation the external receiver's characters and line-break events are forwarded. When the loopback-enable bit of the control register is set, the external receive path is cut off. In that mode, characters written to the data register and rising edges of the send-break control are fed back into the receive FIFO instead.

The block also keeps the four modem-status flags. While loopback is enabled, every control-register write copies the software-driven modem control outputs onto those flags through a fixed cross-mapping. On the same write, a fresh set of modem-status interrupt bits is produced for the interrupt logic, which replaces its four modem bits with them. All outputs are registered and change one clock after the input that causes them. Serial bit timing and flow control are handled elsewhere.

Top module: `uart_loopback_mapper`

## Requirements
- R1: While `rst_n` is low and after its release, `push_valid`, `push_break`, `push_data`, `ms_flags`, `ms_int` and `ms_upd` are all zero and loopback is off.
- R2: Control word bits: 0 loopback enable, 1 DTR, 2 RTS, 3 Out1, 4 Out2. Flag vector bits: 0 ring indicator, 1 clear-to-send, 2 carrier detect, 3 data-set-ready. One cycle after a control write with bit 0 set, ring indicator equals Out2, carrier detect equals Out1, clear-to-send equals RTS, and data-set-ready equals DTR.
- R3: On each such write, `ms_upd` pulses for exactly one cycle and `ms_int` carries the new flags. Bits whose flag is now clear are therefore dropped. This also applies to a write that only sets the loopback bit, with all modem outputs zero.
- R4: A control write with bit 0 clear leaves `ms_flags` and `ms_int` unchanged and raises no `ms_upd`.
- R5: With loopback on, a data-register write pushes that character one cycle later, with `push_break` low.
- R6: With loopback on, a 0-to-1 change of `tx_break` pushes one entry with `push_break` high and `push_data` zero. Holding it at 1 or dropping it to 0 pushes nothing.
- R7: With loopback on, `ext_rx_valid` and `ext_break` never cause a push.
- R8: With loopback off, an external character is pushed as is and an external break pushes a break entry. Data writes and `tx_break` edges push nothing.
- R9: If `fifo_full` is high in the cycle a push would be requested, nothing is pushed and the request is lost. The modem flags are untouched.
- R10: At most one entry is pushed per cycle, and a break outranks a character from the same cycle. The mode used for pushes is the loopback bit held before a control write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctrl_wr | input | 1 | Control-register write strobe |
| ctrl_wdata | input | 5 | Control word being written |
| data_wr | input | 1 | Data-register write strobe |
| data_wdata | input | DATA_W | Character written for transmission |
| tx_break | input | 1 | Send-break control level |
| ext_rx_valid | input | 1 | External receiver has a character |
| ext_rx_data | input | DATA_W | External received character |
| ext_break | input | 1 | External line-break event |
| fifo_full | input | 1 | Receive FIFO cannot accept an entry |
| push_valid | output | 1 | Receive FIFO push strobe |
| push_data | output | DATA_W | Character pushed |
| push_break | output | 1 | Pushed entry is a break marker |
| ms_flags | output | 4 | Modem-status flags |
| ms_int | output | 4 | Modem-status interrupt bits to install |
| ms_upd | output | 1 | Install `ms_int` this cycle |

## Verification
The hardest cases to reach from the ports are the ones where several sources meet in a single cycle. One is a send-break rising edge arriving together with a data write in loopback. Another is a control write that flips the loopback bit in the same cycle as an external character. The directed stimulus raises these strobes together at one clock edge. It then checks that the break wins in the first case, and that the old mode governs the push in the second. The interrupt-clearing step is exercised by two loopback writes in a row whose modem patterns do not overlap, so any stale bit left from the first write shows up in `ms_int`.

// File: rtl/uart_lb_pkg.sv
// Package: shared constants and types for the UART loopback mapper.
// Assumes the control word layout below is fixed by the register decoder.
package uart_lb_pkg;
    localparam int CTRL_W  = 5;
    localparam int CB_LOOP = 0;
    localparam int CB_DTR  = 1;
    localparam int CB_RTS  = 2;
    localparam int CB_OUT1 = 3;
    localparam int CB_OUT2 = 4;

    localparam int MS_W   = 4;
    localparam int MS_RI  = 0;
    localparam int MS_CTS = 1;
    localparam int MS_DCD = 2;
    localparam int MS_DSR = 3;

    typedef enum logic [1:0] {
        SRC_NONE  = 2'd0,
        SRC_TX    = 2'd1,
        SRC_EXT   = 2'd2,
        SRC_BREAK = 2'd3
    } push_src_e;

    // Control bit that drives each modem-status flag in loopback.
    function automatic int ctrl_bit_for(input int ms_idx);
        case (ms_idx)
            MS_RI:   return CB_OUT2;
            MS_CTS:  return CB_RTS;
            MS_DCD:  return CB_OUT1;
            default: return CB_DTR;
        endcase
    endfunction
endpackage

// File: rtl/uart_lb_mode.sv
// Module: holds the loopback-enable bit of the control register.
// Assumes ctrl_wr marks a complete control-register write.
module uart_lb_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic ctrl_wr,
    input  logic loop_bit,
    output logic loop_en
);
    // Capture the loopback bit on every control write.
    always_ff @(posedge clk) begin
        if (!rst_n)       loop_en <= 1'b0;
        else if (ctrl_wr) loop_en <= loop_bit;
    end
endmodule

// File: rtl/uart_lb_modem_map.sv
// Module: maps modem control outputs onto status flags in loopback and
// produces the replacement modem-status interrupt bits.
// Assumes the mapping applies only on writes whose loopback bit is set.
module uart_lb_modem_map
    import uart_lb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    output logic [MS_W-1:0]   ms_flags,
    output logic [MS_W-1:0]   ms_int,
    output logic              ms_upd
);
    logic [MS_W-1:0] mapped;
    logic            apply;

    // Fixed cross-mapping, one flag per modem-status bit.
    for (genvar g = 0; g < MS_W; g++) begin : g_map
        assign mapped[g] = ctrl_wdata[ctrl_bit_for(g)];
    end

    assign apply = ctrl_wr && ctrl_wdata[CB_LOOP];

    // Flags follow the mapped outputs on a loopback write, else hold.
    always_ff @(posedge clk) begin
        if (!rst_n)     ms_flags <= '0;
        else if (apply) ms_flags <= mapped;
    end

    // Interrupt bits: clear all four, then set those whose flag is now on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ms_int <= '0;
            ms_upd <= 1'b0;
        end else begin
            ms_upd <= apply;
            if (apply) ms_int <= ('0 | mapped);
        end
    end
endmodule

// File: rtl/uart_lb_push_mux.sv
// Module: chooses the single receive FIFO push source for each cycle.
// Assumes fifo_full reflects FIFO occupancy in the requesting cycle.
module uart_lb_push_mux
    import uart_lb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loop_en,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              tx_break,
    input  logic              ext_rx_valid,
    input  logic [DATA_W-1:0] ext_rx_data,
    input  logic              ext_break,
    input  logic              fifo_full,
    output logic              push_valid,
    output logic [DATA_W-1:0] push_data,
    output logic              push_break
);
    logic      brk_q;
    logic      brk_rise;
    push_src_e src;

    assign brk_rise = tx_break && !brk_q;

    // Remember the send-break level to find its rising edge.
    always_ff @(posedge clk) begin
        if (!rst_n) brk_q <= 1'b0;
        else        brk_q <= tx_break;
    end

    // Pick the source: break first, then character, gated by FIFO space.
    always_comb begin
        src = SRC_NONE;
        if (loop_en) begin
            if (brk_rise)     src = SRC_BREAK;
            else if (data_wr) src = SRC_TX;
        end else begin
            if (ext_break)         src = SRC_BREAK;
            else if (ext_rx_valid) src = SRC_EXT;
        end
        if (fifo_full) src = SRC_NONE;
    end

    // Register the push towards the receive FIFO.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            push_valid <= 1'b0;
            push_break <= 1'b0;
            push_data  <= '0;
        end else begin
            push_valid <= (src != SRC_NONE);
            push_break <= (src == SRC_BREAK);
            case (src)
                SRC_TX:  push_data <= data_wdata;
                SRC_EXT: push_data <= ext_rx_data;
                default: push_data <= '0;
            endcase
        end
    end
endmodule

// File: rtl/uart_loopback_mapper.sv
// Module: top of the UART loopback and modem-status mapper.
// Assumes all strobes are single-cycle and synchronous to clk.
module uart_loopback_mapper
    import uart_lb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctrl_wr,
    input  logic [4:0]        ctrl_wdata,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_wdata,
    input  logic              tx_break,
    input  logic              ext_rx_valid,
    input  logic [DATA_W-1:0] ext_rx_data,
    input  logic              ext_break,
    input  logic              fifo_full,
    output logic              push_valid,
    output logic [DATA_W-1:0] push_data,
    output logic              push_break,
    output logic [3:0]        ms_flags,
    output logic [3:0]        ms_int,
    output logic              ms_upd
);
    logic loop_en;

    uart_lb_mode u_mode (
        .clk      (clk),
        .rst_n    (rst_n),
        .ctrl_wr  (ctrl_wr),
        .loop_bit (ctrl_wdata[CB_LOOP]),
        .loop_en  (loop_en)
    );

    uart_lb_modem_map u_map (
        .clk        (clk),
        .rst_n      (rst_n),
        .ctrl_wr    (ctrl_wr),
        .ctrl_wdata (ctrl_wdata),
        .ms_flags   (ms_flags),
        .ms_int     (ms_int),
        .ms_upd     (ms_upd)
    );

    uart_lb_push_mux #(.DATA_W(DATA_W)) u_mux (
        .clk          (clk),
        .rst_n        (rst_n),
        .loop_en      (loop_en),
        .data_wr      (data_wr),
        .data_wdata   (data_wdata),
        .tx_break     (tx_break),
        .ext_rx_valid (ext_rx_valid),
        .ext_rx_data  (ext_rx_data),
        .ext_break    (ext_break),
        .fifo_full    (fifo_full),
        .push_valid   (push_valid),
        .push_data    (push_data),
        .push_break   (push_break)
    );
endmodule

// File: rtl/uart_lb_checker.sv
// Module: property checker for the loopback mapper, bound to the top.
// Assumes it sees the top's ports and its registered loopback bit.
module uart_lb_checker
    import uart_lb_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              loop_en,
    input logic              ctrl_wr,
    input logic [4:0]        ctrl_wdata,
    input logic              data_wr,
    input logic [DATA_W-1:0] data_wdata,
    input logic              ext_rx_valid,
    input logic [DATA_W-1:0] ext_rx_data,
    input logic              fifo_full,
    input logic              push_valid,
    input logic [DATA_W-1:0] push_data,
    input logic              push_break,
    input logic [3:0]        ms_flags,
    input logic [3:0]        ms_int,
    input logic              ms_upd
);
    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        $past(fifo_full) |-> !push_valid); // R9

    AST_INT_EQ_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        ms_upd |-> ms_int == ms_flags); // R3

    AST_UPD_NEEDS_LOOP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ms_upd |-> ($past(ctrl_wr) && $past(ctrl_wdata[CB_LOOP]))); // R4

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !ms_upd |-> $stable(ms_flags)); // R4

    AST_CROSS_MAP: assert property (@(posedge clk) disable iff (!rst_n)
        ms_upd |-> ms_flags == {$past(ctrl_wdata[CB_DTR]), $past(ctrl_wdata[CB_OUT1]),
                                $past(ctrl_wdata[CB_RTS]), $past(ctrl_wdata[CB_OUT2])}); // R2

    AST_BREAK_ENTRY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && push_break) |-> push_data == '0); // R6

    AST_LOOP_CHAR_FROM_TX: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_break && $past(loop_en)) |-> ($past(data_wr) && push_data == $past(data_wdata))); // R5

    AST_NORMAL_CHAR_FROM_EXT: assert property (@(posedge clk) disable iff (!rst_n)
        (push_valid && !push_break && !$past(loop_en)) |-> ($past(ext_rx_valid) && push_data == $past(ext_rx_data))); // R8
endmodule

bind uart_loopback_mapper uart_lb_checker #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .loop_en      (loop_en),
    .ctrl_wr      (ctrl_wr),
    .ctrl_wdata   (ctrl_wdata),
    .data_wr      (data_wr),
    .data_wdata   (data_wdata),
    .ext_rx_valid (ext_rx_valid),
    .ext_rx_data  (ext_rx_data),
    .fifo_full    (fifo_full),
    .push_valid   (push_valid),
    .push_data    (push_data),
    .push_break   (push_break),
    .ms_flags     (ms_flags),
    .ms_int       (ms_int),
    .ms_upd       (ms_upd)
);

// File: tb/tb_uart_loopback_mapper.sv
module tb_uart_loopback_mapper;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctrl_wr = 1'b0;
    logic [4:0]    ctrl_wdata = '0;
    logic          data_wr = 1'b0;
    logic [DW-1:0] data_wdata = '0;
    logic          tx_break = 1'b0;
    logic          ext_rx_valid = 1'b0;
    logic [DW-1:0] ext_rx_data = '0;
    logic          ext_break = 1'b0;
    logic          fifo_full = 1'b0;
    logic          push_valid;
    logic [DW-1:0] push_data;
    logic          push_break;
    logic [3:0]    ms_flags;
    logic [3:0]    ms_int;
    logic          ms_upd;

    int total = 0;
    int bad = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    uart_loopback_mapper #(.DATA_W(DW)) dut (.*);

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic expect_push(input logic v, input logic brk, input logic [DW-1:0] d, input string tag);
        chk(push_valid == v, {tag, " valid"}, push_valid, v);
        if (v) begin
            chk(push_break == brk, {tag, " break"}, push_break, brk);
            chk(push_data == d, {tag, " data"}, push_data, d);
        end
    endtask

    task automatic expect_ms(input logic upd, input logic [3:0] fl, input string tag);
        chk(ms_upd == upd, {tag, " upd"}, ms_upd, upd);
        chk(ms_flags == fl, {tag, " flags"}, ms_flags, fl);
        if (upd) chk(ms_int == fl, {tag, " int"}, ms_int, fl);
    endtask

    // One cycle: inputs set at a falling edge are taken at the next rise.
    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic clear_strobes();
        ctrl_wr = 0; data_wr = 0; ext_rx_valid = 0; ext_break = 0;
    endtask

    task automatic t_reset();
        cyc(); cyc();
        expect_push(1'b0, 1'b0, '0, "R1 reset");
        expect_ms(1'b0, 4'b0000, "R1 reset");
        rst_n = 1'b1;
        cyc();
        expect_push(1'b0, 1'b0, '0, "R1 after release");
        expect_ms(1'b0, 4'b0000, "R1 after release");
    endtask

    task automatic t_normal();
        ext_rx_valid = 1; ext_rx_data = 8'h5A; cyc(); clear_strobes();
        expect_push(1'b1, 1'b0, 8'h5A, "R8 ext char");
        ext_break = 1; cyc(); clear_strobes();
        expect_push(1'b1, 1'b1, '0, "R8 ext break");
        data_wr = 1; data_wdata = 8'h33; cyc(); clear_strobes();
        expect_push(1'b0, 1'b0, '0, "R8 data write ignored");
        tx_break = 1; cyc();
        expect_push(1'b0, 1'b0, '0, "R8 send-break ignored");
        tx_break = 0; cyc();
        ext_break = 1; ext_rx_valid = 1; ext_rx_data = 8'h11; cyc(); clear_strobes();
        expect_push(1'b1, 1'b1, '0, "R10 ext break beats char");
    endtask

    task automatic t_map();
        ctrl_wr = 1; ctrl_wdata = 5'b00001; cyc(); clear_strobes();
        expect_ms(1'b1, 4'b0000, "R3 loop-only write");
        cyc();
        chk(ms_upd == 1'b0, "R3 single pulse", ms_upd, 0);
        ctrl_wr = 1; ctrl_wdata = 5'b10011; cyc(); clear_strobes();
        expect_ms(1'b1, 4'b1001, "R2 out2+dtr");
        ctrl_wr = 1; ctrl_wdata = 5'b01101; cyc(); clear_strobes();
        expect_ms(1'b1, 4'b0110, "R3 stale bits cleared");
    endtask

    task automatic t_loop_push();
        data_wr = 1; data_wdata = 8'hA5; cyc(); clear_strobes();
        expect_push(1'b1, 1'b0, 8'hA5, "R5 loop char");
        ext_rx_valid = 1; ext_rx_data = 8'h77; cyc(); clear_strobes();
        expect_push(1'b0, 1'b0, '0, "R7 ext char ignored");
        ext_break = 1; cyc(); clear_strobes();
        expect_push(1'b0, 1'b0, '0, "R7 ext break ignored");
        tx_break = 1; cyc();
        expect_push(1'b1, 1'b1, '0, "R6 break rise");
        cyc();
        expect_push(1'b0, 1'b0, '0, "R6 break held");
        tx_break = 0; cyc();
        expect_push(1'b0, 1'b0, '0, "R6 break fall");
        tx_break = 1; data_wr = 1; data_wdata = 8'h42; cyc(); clear_strobes();
        expect_push(1'b1, 1'b1, '0, "R10 break beats char");
        tx_break = 0; cyc();
    endtask

    task automatic t_full();
        fifo_full = 1; data_wr = 1; data_wdata = 8'hC3; cyc(); clear_strobes();
        expect_push(1'b0, 1'b0, '0, "R9 full drop");
        expect_ms(1'b0, 4'b0110, "R9 flags untouched");
        fifo_full = 0; cyc();
        expect_push(1'b0, 1'b0, '0, "R9 no late push");
    endtask

    task automatic t_disable();
        ctrl_wr = 1; ctrl_wdata = 5'b00010; ext_rx_valid = 1; ext_rx_data = 8'h99;
        cyc(); clear_strobes();
        expect_ms(1'b0, 4'b0110, "R4 non-loop write holds");
        expect_push(1'b0, 1'b0, '0, "R10 old loop mode governs");
        ext_rx_valid = 1; ext_rx_data = 8'h3C; cyc(); clear_strobes();
        expect_push(1'b1, 1'b0, 8'h3C, "R8 ext after disable");
        ctrl_wr = 1; ctrl_wdata = 5'b00001; ext_rx_valid = 1; ext_rx_data = 8'hE1;
        cyc(); clear_strobes();
        expect_push(1'b1, 1'b0, 8'hE1, "R10 old normal mode governs");
        expect_ms(1'b1, 4'b0000, "R3 re-enable clears");
    endtask

    initial begin
        t_reset();
        t_normal();
        t_map();
        t_loop_push();
        t_full();
        t_disable();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule